// File: doc/BRIEF.md
# Regulator Power-Up Sequencer

This block brings up a charge pump and three switching-converter enables (A, B and C) once the supply-good flag is high and the external reset input has been released. When a sequence starts it stores a two-bit three-level select code and a parallel-mode pin. These stored values decide whether any converter starts and which group comes first. The charge pump starts first and runs for a lead time. The first group then turns on, and the second group follows after a gap. A separate timer releases the active-low reset output a fixed time after the sequence starts.

The reset input is active high. It passes through a two-stage synchronizer and a deglitch filter, and it comes out of reset in the asserted state, as if the pin were left open. If the filtered reset is asserted, or supply-good drops, every enable and the reset output fall together. The sequence then waits for the next start. Three per-channel off bits from the setup register mask the converter enables. The motor-enable output follows the sleep input, but only while the block is not held in reset. All delays are parameters counted in clock cycles, and every output is registered.

Top module: `pwrseq_ctrl`

## Requirements
- R1: While `rst_i` is high, and on the first cycle after it, every output is low (`rst_out_n_o` low).
- R2: A level change on `rst_pin_i` has effect only after it has held for `FILT_CYC` consecutive cycles, counted after two synchronizer stages. A shorter pulse is ignored.
- R3: `sel_code_i` and `par_mode_i` are stored on the start edge, which is the first edge where supply-good is high and the filtered reset is low. Later changes have no effect until the next start.
- R4: `cp_en_o` rises on the start edge (when sleep is high). The first converter group turns on `CP_LEAD_CYC` edges after the start edge.
- R5: With the stored mode low, the select code 2'b10 (open) starts A first and then B and C. Every other code (2'b00 ground, 2'b01 pull-down, 2'b11) starts no converter.
- R6: With the stored mode high, 2'b00 and 2'b11 start nothing, 2'b01 starts B and C first and then A, and 2'b10 starts A first and then B and C.
- R7: The second group turns on `GROUP_GAP_CYC` edges after the first. B and C always turn on together.
- R8: `rst_out_n_o` goes high `RST_HOLD_CYC` edges after the start edge.
- R9: Once supply-good is low or the filtered reset is asserted at an edge, every enable, `cp_en_o`, `motor_en_o` and `rst_out_n_o` are low after that edge.
- R10: `reg_off_i` bit 0 masks A, bit 1 masks B and bit 2 masks C, one edge after they are applied. Bit 2 is ignored when the stored mode is high.
- R11: `cp_en_o` is low when sleep is low and no converter is enabled. It stays high while any converter is enabled.
- R12: `motor_en_o` is high only when supply-good is high, the filtered reset is low and `sleep_n_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Supply-good flag from the analog threshold |
| rst_pin_i | input | 1 | External reset input, active high, asynchronous |
| sel_code_i | input | 2 | Three-level select: 00 ground, 01 pull-down, 10 open, 11 as ground |
| par_mode_i | input | 1 | Parallel-mode pin |
| sleep_n_i | input | 1 | Sleep control, low means sleep |
| reg_off_i | input | 3 | Setup-register off bits: bit0 A, bit1 B, bit2 C |
| cp_en_o | output | 1 | Charge-pump enable |
| conv_en_o | output | 3 | Converter enables: bit0 A, bit1 B, bit2 C |
| rst_out_n_o | output | 1 | Reset output, active low |
| motor_en_o | output | 1 | Motor-driver enable |

## Verification
Two events can land on the same edge: the second group turning on, and either an off-bit change or a loss of supply-good. The bench counts edges from the start edge. It applies the off bit for B, or drops supply-good, so that the value is sampled on exactly the edge where B and C would turn on. In the off-bit case, B must stay low while C comes on. In the supply-loss case, nothing from the second group may appear and everything must fall. A behavioural reference model, compared on every cycle, also judges these edges.

// File: rtl/psq_pkg.sv
package psq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_GAP,
    ST_RUN
  } psq_state_t;

  typedef enum logic [1:0] {
    ORD_NONE,
    ORD_A_FIRST,
    ORD_BC_FIRST
  } psq_order_t;

  localparam logic [1:0] SEL_GND  = 2'b00;
  localparam logic [1:0] SEL_PD   = 2'b01;
  localparam logic [1:0] SEL_OPEN = 2'b10;

  localparam int unsigned CH_A = 0;
  localparam int unsigned CH_B = 1;
  localparam int unsigned CH_C = 2;
  localparam int unsigned N_CH = 3;
endpackage

// File: rtl/psq_deglitch.sv
module psq_deglitch #(
  parameter int unsigned FILT_CYC    = 250,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        RESET_VAL   = 1'b1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   sync_last;

  assign sync_last = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i) begin
    if (rst_i) sync_q <= {SYNC_STAGES{RESET_VAL}};
    else       sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      filt_o <= RESET_VAL;
      cnt_q  <= '0;
    end else if (sync_last == filt_o) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT_CYC - 1)) begin
      filt_o <= sync_last;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: the filtered level only moves toward the synchronized input
  a_r2_change_needs_diff: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(filt_o) |-> ($past(sync_last) == filt_o));
endmodule

// File: rtl/psq_order_dec.sv
module psq_order_dec
  import psq_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       mode_i,
  output psq_order_t order_o
);
  always_comb begin
    order_o = ORD_NONE;
    unique case (sel_i)
      SEL_OPEN: order_o = ORD_A_FIRST;
      SEL_PD:   order_o = mode_i ? ORD_BC_FIRST : ORD_NONE;
      default:  order_o = ORD_NONE;
    endcase
  end
endmodule

// File: rtl/psq_hold_timer.sv
module psq_hold_timer #(
  parameter int unsigned HOLD_CYC = 15000000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic go_i,
  input  logic start_i,
  output logic rel_o
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);

  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !go_i) begin
      cnt_q <= '0;
      rel_o <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
    end else if (!rel_o) begin
      if (cnt_q == HW'(HOLD_CYC - 1)) rel_o <= 1'b1;
      else                            cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8: the release is only held while the start condition persists
  a_r8_rel_only_with_go: assert property (@(posedge clk_i) disable iff (rst_i)
    rel_o |-> $past(go_i));
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import psq_pkg::*;
#(
  parameter int unsigned FILT_CYC      = 250,
  parameter int unsigned CP_LEAD_CYC   = 500000,
  parameter int unsigned GROUP_GAP_CYC = 80000,
  parameter int unsigned RST_HOLD_CYC  = 15000000
) (
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        supply_ok_i,
  input  logic        rst_pin_i,
  input  logic [1:0]  sel_code_i,
  input  logic        par_mode_i,
  input  logic        sleep_n_i,
  input  logic [2:0]  reg_off_i,
  output logic        cp_en_o,
  output logic [2:0]  conv_en_o,
  output logic        rst_out_n_o,
  output logic        motor_en_o
);
  localparam int unsigned MAXD = (CP_LEAD_CYC > GROUP_GAP_CYC) ? CP_LEAD_CYC : GROUP_GAP_CYC;
  localparam int unsigned TW   = $clog2(MAXD + 1);

  logic             rst_filt, go, go_q, start;
  logic [1:0]       sel_cap;
  logic             mode_cap;
  psq_order_t       order;
  psq_state_t       state_q, state_nxt;
  logic [TW-1:0]    tmr_q, tmr_nxt;
  logic             grp1, grp2, a_on, bc_on;
  logic [N_CH-1:0]  ch_on, en_nxt;

  psq_deglitch #(.FILT_CYC(FILT_CYC), .SYNC_STAGES(2), .RESET_VAL(1'b1)) u_dg (
    .clk_i(clk_i), .rst_i(rst_i), .raw_i(rst_pin_i), .filt_o(rst_filt)
  );

  assign go    = supply_ok_i & ~rst_filt;
  assign start = go & ~go_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      go_q     <= 1'b0;
      sel_cap  <= SEL_GND;
      mode_cap <= 1'b0;
    end else begin
      go_q <= go;
      if (start) begin
        sel_cap  <= sel_code_i;
        mode_cap <= par_mode_i;
      end
    end
  end

  psq_order_dec u_dec (.sel_i(sel_cap), .mode_i(mode_cap), .order_o(order));

  always_comb begin
    state_nxt = state_q;
    tmr_nxt   = tmr_q;
    if (!go) begin
      state_nxt = ST_IDLE;
      tmr_nxt   = '0;
    end else if (start) begin
      state_nxt = ST_LEAD;
      tmr_nxt   = '0;
    end else begin
      case (state_q)
        ST_LEAD:
          if (tmr_q == TW'(CP_LEAD_CYC - 1)) begin
            state_nxt = ST_GAP;
            tmr_nxt   = '0;
          end else tmr_nxt = tmr_q + 1'b1;
        ST_GAP:
          if (tmr_q == TW'(GROUP_GAP_CYC - 1)) begin
            state_nxt = ST_RUN;
            tmr_nxt   = '0;
          end else tmr_nxt = tmr_q + 1'b1;
        default: ;
      endcase
    end
  end

  assign grp1  = (state_nxt == ST_GAP) || (state_nxt == ST_RUN);
  assign grp2  = (state_nxt == ST_RUN);
  assign a_on  = ((order == ORD_A_FIRST) && grp1) || ((order == ORD_BC_FIRST) && grp2);
  assign bc_on = ((order == ORD_A_FIRST) && grp2) || ((order == ORD_BC_FIRST) && grp1);

  assign ch_on[CH_A] = a_on;
  assign ch_on[CH_B] = bc_on;
  assign ch_on[CH_C] = bc_on;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    if (i == CH_C) begin : g_c
      assign en_nxt[i] = ch_on[i] & ~(reg_off_i[i] & ~mode_cap);
    end else begin : g_ab
      assign en_nxt[i] = ch_on[i] & ~reg_off_i[i];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q    <= ST_IDLE;
      tmr_q      <= '0;
      conv_en_o  <= '0;
      cp_en_o    <= 1'b0;
      motor_en_o <= 1'b0;
    end else begin
      state_q    <= state_nxt;
      tmr_q      <= tmr_nxt;
      conv_en_o  <= en_nxt;
      cp_en_o    <= (state_nxt != ST_IDLE) && (sleep_n_i || (|en_nxt));
      motor_en_o <= go & sleep_n_i;
    end
  end

  psq_hold_timer #(.HOLD_CYC(RST_HOLD_CYC)) u_hold (
    .clk_i(clk_i), .rst_i(rst_i), .go_i(go), .start_i(start), .rel_o(rst_out_n_o)
  );

  // R9: losing the start condition clears every output on the next edge
  a_r9_all_off_without_go: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(go) |-> (conv_en_o == 3'b000) && !cp_en_o && !motor_en_o && !rst_out_n_o);
  // R11: any running converter keeps the charge pump on
  a_r11_cp_covers_regs: assert property (@(posedge clk_i) disable iff (rst_i)
    (|conv_en_o) |-> cp_en_o);
  // R4: the charge pump comes on before any converter
  a_r4_pump_leads: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(cp_en_o) |-> (conv_en_o == 3'b000));
  // R7: B may only turn on while C is allowed on too, unless C is masked
  a_r7_b_with_c: assert property (@(posedge clk_i) disable iff (rst_i)
    (conv_en_o[CH_B] && !$past(reg_off_i[CH_C])) |-> conv_en_o[CH_C]);
endmodule

// File: tb/sim_pwrseq_ctrl.sv
module sim_pwrseq_ctrl;
  localparam int DG   = 4;
  localparam int LEAD = 20;
  localparam int GAP  = 12;
  localparam int HOLD = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0, rst_pin = 1'b1, par_mode = 1'b0, sleep_n = 1'b1;
  logic [1:0] sel = 2'b00;
  logic [2:0] off = 3'b000;
  logic cp_en, rst_out_n, motor_en;
  logic [2:0] conv_en;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwrseq_ctrl #(.FILT_CYC(DG), .CP_LEAD_CYC(LEAD), .GROUP_GAP_CYC(GAP), .RST_HOLD_CYC(HOLD)) u0 (
    .clk_i(clk), .rst_i(rst), .supply_ok_i(supply_ok), .rst_pin_i(rst_pin),
    .sel_code_i(sel), .par_mode_i(par_mode), .sleep_n_i(sleep_n), .reg_off_i(off),
    .cp_en_o(cp_en), .conv_en_o(conv_en), .rst_out_n_o(rst_out_n), .motor_en_o(motor_en)
  );

  // reference model, time-stamp based
  int   cyc = 0, t0 = 0, run = 0;
  logic m_s1, m_s2, m_filt, m_goq;
  logic [1:0] m_sel;
  logic m_mode;
  logic m_cp, m_rel, m_mot;
  logic [2:0] m_en;

  always @(posedge clk) begin
    logic g, st, g1, g2, afirst, bcfirst, aon, bcon;
    int el;
    cyc++;
    if (rst) begin
      m_s1 = 1; m_s2 = 1; m_filt = 1; run = 0; m_goq = 0;
      m_sel = 0; m_mode = 0; m_cp = 0; m_rel = 0; m_mot = 0; m_en = 0;
    end else begin
      g  = supply_ok && !m_filt;
      st = g && !m_goq;
      m_goq = g;
      if (m_s2 != m_filt) begin
        run++;
        if (run == DG) begin m_filt = m_s2; run = 0; end
      end else run = 0;
      m_s2 = m_s1; m_s1 = rst_pin;
      if (!g) begin
        m_cp = 0; m_rel = 0; m_mot = 0; m_en = 0;
      end else begin
        if (st) begin t0 = cyc; m_sel = sel; m_mode = par_mode; end
        el = cyc - t0;
        g1 = (el >= LEAD);
        g2 = (el >= LEAD + GAP);
        afirst  = (m_sel == 2'b10);
        bcfirst = (m_sel == 2'b01) && m_mode;
        aon  = afirst ? g1 : (bcfirst ? g2 : 1'b0);
        bcon = afirst ? g2 : (bcfirst ? g1 : 1'b0);
        m_en[0] = aon && !off[0];
        m_en[1] = bcon && !off[1];
        m_en[2] = bcon && !(off[2] && !m_mode);
        m_cp  = sleep_n || (m_en != 0);
        m_rel = (el >= HOLD);
        m_mot = sleep_n;
      end
    end
  end

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R4/R11 cp_en model", {2'b0, cp_en}, {2'b0, m_cp});
      chk("R5/R6/R7/R10 conv_en model", conv_en, m_en);
      chk("R8 rst_out_n model", {2'b0, rst_out_n}, {2'b0, m_rel});
      chk("R12 motor_en model", {2'b0, motor_en}, {2'b0, m_mot});
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input logic [1:0] s, input logic m);
    @(negedge clk);
    supply_ok = 0; sel = s; par_mode = m;
    step(2);
    supply_ok = 1;
  endtask

  initial begin
    step(3);
    chk("R1 reset cp", {2'b0, cp_en}, 3'b0);
    chk("R1 reset conv", conv_en, 3'b0);
    chk("R1 reset rst_out_n", {2'b0, rst_out_n}, 3'b0);
    rst = 0;
    step(1);
    chk("R1 after reset", {cp_en, rst_out_n, motor_en}, 3'b0);
    supply_ok = 1; sel = 2'b10;
    step(2);
    rst_pin = 0; step(DG - 1); rst_pin = 1;
    step(10);
    chk("R2 short pulse ignored", {2'b0, cp_en}, 3'b0);
    rst_pin = 0;
    step(DG + 5);
    chk("R2 long release starts", {2'b0, cp_en}, 3'b1);
    step(HOLD + 5);

    // mode low, open: A then BC
    restart(2'b10, 0);
    step(LEAD);
    chk("R4 no converter before lead", conv_en, 3'b000);
    chk("R4 pump on", {2'b0, cp_en}, 3'b001);
    step(1);
    chk("R5 A first", conv_en, 3'b001);
    step(GAP - 1);
    chk("R7 BC not yet", conv_en, 3'b001);
    step(1);
    chk("R7 BC together", conv_en, 3'b111);
    step(HOLD - (LEAD + GAP + 1));
    chk("R8 reset still low", {2'b0, rst_out_n}, 3'b0);
    step(1);
    chk("R8 reset released", {2'b0, rst_out_n}, 3'b1);
    off = 3'b100; step(1);
    chk("R10 C off in mode low", conv_en, 3'b011);
    off = 3'b001; step(1);
    chk("R10 A off", conv_en, 3'b110);
    off = 3'b000;
    sleep_n = 0; step(1);
    chk("R12 motor off in sleep", {2'b0, motor_en}, 3'b0);
    chk("R11 pump kept by converters", {2'b0, cp_en}, 3'b1);
    sleep_n = 1;

    // mode low, pull-down: nothing
    restart(2'b01, 0);
    step(LEAD + GAP + 2);
    chk("R5 pull-down mode low none", conv_en, 3'b000);
    sleep_n = 0; step(1);
    chk("R11 pump off in sleep", {2'b0, cp_en}, 3'b0);
    sleep_n = 1; step(1);
    chk("R11 pump back", {2'b0, cp_en}, 3'b1);

    restart(2'b00, 1);
    step(LEAD + GAP + 2);
    chk("R6 ground none", conv_en, 3'b000);
    restart(2'b11, 1);
    step(LEAD + GAP + 2);
    chk("R6 code 11 none", conv_en, 3'b000);

    // mode high, pull-down: BC then A
    restart(2'b01, 1);
    step(LEAD + 1);
    chk("R6 BC first", conv_en, 3'b110);
    step(GAP);
    chk("R6 A second", conv_en, 3'b111);
    off = 3'b100; step(1);
    chk("R10 C bit ignored mode high", conv_en, 3'b111);
    off = 3'b000;

    // capture held
    restart(2'b10, 1);
    step(3);
    sel = 2'b00; par_mode = 0;
    step(LEAD - 2);
    chk("R3 captured select kept", conv_en, 3'b001);
    step(GAP);
    chk("R3 second group kept", conv_en, 3'b111);

    // collision: off bit on the BC turn-on edge
    restart(2'b10, 1);
    step(LEAD + GAP);
    off = 3'b010; step(1);
    chk("R10 off B at turn-on edge", conv_en, 3'b101);
    off = 3'b000;

    // collision: supply loss on the BC turn-on edge
    restart(2'b10, 1);
    step(LEAD + GAP);
    supply_ok = 0; step(1);
    chk("R9 supply loss at turn-on edge", conv_en, 3'b000);
    chk("R9 pump and reset off", {1'b0, cp_en, rst_out_n}, 3'b000);
    supply_ok = 1;

    // reset input asserted while running
    restart(2'b10, 0);
    step(HOLD + 2);
    rst_pin = 1;
    step(DG + 2);
    chk("R2 reset not yet effective", conv_en, 3'b111);
    step(1);
    chk("R9 reset input clears", {cp_en, rst_out_n, motor_en}, 3'b000);
    chk("R9 converters cleared", conv_en, 3'b000);
    step(4);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule